// File: doc/BRIEF.md
# Single-Wire Bus Transceiver Mode Controller

This block is the operating-state sequencer of a single-wire bus transceiver. It runs one of four modes: unpowered, standby, normal and sleep. The mode is chosen from a supply-below-reset flag, a digitally filtered enable input, and wake pulses that a separate detector reports for the bus and for a local wake pin. From the mode, the block drives the pin configuration seen by the analog front end. This covers whether the receive pin is released, pulled low or carrying bus data, and the strength of the transmit-pin pull-down. It also sets the regulator-inhibit switch and the type of bus termination.

Standby records where the chip came from. After power-up both pins stay quiet. After a wake the receive pin is held low, and the transmit pull-down shows the wake source: strong for a local wake, weak for a bus wake. These settings are dropped on the first clock that sees enable high, so they can never fight the controller that is about to drive the transmit pin. The enable filter does not need to finish first. An output marks the window in which normal mode is counting down towards sleep. A wake pulse that arrives in this window sends the chip to standby instead of sleep.

Top module: `linmc_top`

## Requirements
- R1: While `porLow` is sampled high at a clock edge, `modeOut` becomes 0 (unpowered) after that edge, from any mode. Mode codes are 0 unpowered, 1 standby, 2 normal and 3 sleep. In unpowered, `rxdLow`, `txdStrong` and `inhOn` are 0 and `termSel` is 0.
- R2: In unpowered, the first edge that samples `porLow` low moves to standby, with `rxdLow` = 0 and `txdStrong` = 0.
- R3: From standby or sleep, the mode becomes normal at the clock edge that has sampled `enIn` high on EN_CYCLES consecutive edges. Fewer such edges leave the mode unchanged.
- R4: From normal, the mode becomes sleep at the edge that has sampled `enIn` low on DIS_CYCLES consecutive edges.
- R5: If `enIn` returns to the other level before the filter finishes, the count restarts from zero.
- R6: In sleep, a `wakeBus` or `wakeLocal` pulse moves the mode to standby at the next edge, with `rxdLow` = 1. `txdStrong` is then 1 if `wakeLocal` was set and 0 for a bus-only wake.
- R7: In normal with `enIn` low, a wake pulse is accepted and gives the same standby settings as R6. In normal with `enIn` high, a wake pulse has no effect.
- R8: In standby, wake pulses change neither the mode nor `rxdLow` or `txdStrong`.
- R9: In standby, the first edge that samples `enIn` high clears `rxdLow` and `txdStrong`. They stay clear if `enIn` drops again before the filter finishes.
- R10: `inhOn` is 1 in standby and normal, and 0 in sleep and unpowered. `termSel` is 1 (resistor) in standby and normal, 2 (weak current source) in sleep, and 0 (floating) in unpowered.
- R11: In normal, `rxdLow` follows `busDominant` in the same cycle. In the other modes, `busDominant` has no effect on `rxdLow`.
- R12: `sleepPending` is 1 exactly when the mode is normal and `enIn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, forces unpowered |
| porLow | input | 1 | Supply below power-on-reset level |
| enIn | input | 1 | Enable input, synchronised |
| wakeBus | input | 1 | One-cycle pulse: bus wake detected |
| wakeLocal | input | 1 | One-cycle pulse: local wake pin event detected |
| busDominant | input | 1 | Received bus level, 1 = dominant |
| modeOut | output | 2 | Current mode code |
| rxdLow | output | 1 | 1 = receive pin pulled low, 0 = released |
| txdStrong | output | 1 | 1 = strong transmit pull-down, 0 = weak |
| inhOn | output | 1 | 1 = inhibit switch on, 0 = floating |
| termSel | output | 2 | Bus termination: 0 floating, 1 resistor, 2 current source |
| sleepPending | output | 1 | Normal-to-sleep filter window is open |

## Verification
The bench checks the enable filter at exactly N-1 and N edges, and again after a glitch that restarts the count. A design that counts one edge too early, or that does not restart the count, changes mode one or more cycles away from the expected edge. A wake pulse that arrives inside the sleep-entry window must go to standby. A design that ignores it goes to sleep, and one that also accepts wakes while enable is high leaves normal mode without cause. The bench applies repeated wakes in standby and a short enable pulse there. These catch a design that overwrites the recorded wake source, or one that restores the low receive pin when enable falls again.

// File: rtl/linmc_pkg.sv
package linmc_pkg;

  typedef enum logic [1:0] {
    MODE_UNPOW = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_NORM  = 2'd2,
    MODE_SLEEP = 2'd3
  } linMode_e;

  typedef enum logic [1:0] {
    TERM_FLOAT = 2'd0,
    TERM_RES   = 2'd1,
    TERM_CSRC  = 2'd2
  } linTerm_e;

  // strobes from the mode sequencer to the pin/filter datapath
  typedef struct packed {
    logic cntClear;   // restart enable filter (mode change)
    logic cfgRelease; // standby pins back to quiet setting
    logic cfgWake;    // record a wake entry into standby
    logic wakeLocal;  // source of the recorded wake
  } ctrlStrb_t;

endpackage

// File: rtl/linmc_ctrl.sv
module linmc_ctrl
  import linmc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      porLow,
  input  logic      enIn,
  input  logic      wakeBus,
  input  logic      wakeLocal,
  input  logic      filtDone,
  output linMode_e  mode,
  output ctrlStrb_t strb
);

  linMode_e modeNext;
  logic     anyWake;

  assign anyWake = wakeBus | wakeLocal;

  always_comb begin
    modeNext = mode;
    strb     = '0;
    if (porLow) begin
      modeNext = MODE_UNPOW;
    end else begin
      unique case (mode)
        MODE_UNPOW: begin
          modeNext        = MODE_STBY;
          strb.cfgRelease = 1'b1;
        end
        MODE_STBY: begin
          // wake events are ignored here; enable drops the wake pin setup at once
          strb.cfgRelease = enIn;
          if (filtDone) modeNext = MODE_NORM;
        end
        MODE_NORM: begin
          if (!enIn && anyWake) begin
            modeNext       = MODE_STBY;
            strb.cfgWake   = 1'b1;
            strb.wakeLocal = wakeLocal;
          end else if (filtDone) begin
            modeNext = MODE_SLEEP;
          end
        end
        MODE_SLEEP: begin
          if (anyWake) begin
            modeNext       = MODE_STBY;
            strb.cfgWake   = 1'b1;
            strb.wakeLocal = wakeLocal;
          end else if (filtDone) begin
            modeNext = MODE_NORM;
          end
        end
        default: modeNext = MODE_UNPOW;
      endcase
    end
    strb.cntClear = (modeNext != mode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_UNPOW;
    else       mode <= modeNext;
  end

endmodule

// File: rtl/linmc_path.sv
module linmc_path
  import linmc_pkg::*;
#(
  parameter int EN_CYCLES  = 4,
  parameter int DIS_CYCLES = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  linMode_e  mode,
  input  ctrlStrb_t strb,
  input  logic      enIn,
  input  logic      busDominant,
  output logic      filtDone,
  output logic      rxdLow,
  output logic      txdStrong,
  output logic      inhOn,
  output linTerm_e  termSel,
  output logic      sleepPending
);

  localparam int MAX_CYC = (EN_CYCLES > DIS_CYCLES) ? EN_CYCLES : DIS_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] EN_LAST  = CNT_W'(EN_CYCLES - 1);
  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(DIS_CYCLES - 1);

  logic [CNT_W-1:0] filtCnt;
  logic [CNT_W-1:0] cntLast;
  logic             targetLvl;
  logic             atTarget;
  logic             atLast;
  logic             rxdLowCfg;
  logic             txdStrongCfg;

  // normal counts low time towards sleep; other modes count high time
  assign targetLvl = (mode != MODE_NORM);
  assign cntLast   = (mode == MODE_NORM) ? DIS_LAST : EN_LAST;
  assign atTarget  = (enIn == targetLvl);
  assign atLast    = (filtCnt == cntLast);
  assign filtDone  = atTarget && atLast && (mode != MODE_UNPOW);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           filtCnt <= '0;
    else if (strb.cntClear || !atTarget) filtCnt <= '0;
    else if (atLast)                     filtCnt <= '0;
    else                                 filtCnt <= filtCnt + 1'b1;
  end

  // standby pin setup, remembered from the entry path
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxdLowCfg    <= 1'b0;
      txdStrongCfg <= 1'b0;
    end else if (strb.cfgWake) begin
      rxdLowCfg    <= 1'b1;
      txdStrongCfg <= strb.wakeLocal;
    end else if (strb.cfgRelease) begin
      rxdLowCfg    <= 1'b0;
      txdStrongCfg <= 1'b0;
    end
  end

  always_comb begin
    rxdLow    = 1'b0;
    txdStrong = 1'b0;
    inhOn     = 1'b0;
    termSel   = TERM_FLOAT;
    unique case (mode)
      MODE_STBY: begin
        rxdLow    = rxdLowCfg;
        txdStrong = txdStrongCfg;
        inhOn     = 1'b1;
        termSel   = TERM_RES;
      end
      MODE_NORM: begin
        rxdLow  = busDominant;
        inhOn   = 1'b1;
        termSel = TERM_RES;
      end
      MODE_SLEEP: termSel = TERM_CSRC;
      default: ;
    endcase
  end

  assign sleepPending = (mode == MODE_NORM) && !enIn;

endmodule

// File: rtl/linmc_top.sv
module linmc_top
  import linmc_pkg::*;
#(
  parameter int EN_CYCLES  = 4,
  parameter int DIS_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       porLow,
  input  logic       enIn,
  input  logic       wakeBus,
  input  logic       wakeLocal,
  input  logic       busDominant,
  output logic [1:0] modeOut,
  output logic       rxdLow,
  output logic       txdStrong,
  output logic       inhOn,
  output logic [1:0] termSel,
  output logic       sleepPending
);

  linMode_e  mode;
  ctrlStrb_t strb;
  linTerm_e  termEnc;
  logic      filtDone;

  linmc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .porLow    (porLow),
    .enIn      (enIn),
    .wakeBus   (wakeBus),
    .wakeLocal (wakeLocal),
    .filtDone  (filtDone),
    .mode      (mode),
    .strb      (strb)
  );

  linmc_path #(
    .EN_CYCLES  (EN_CYCLES),
    .DIS_CYCLES (DIS_CYCLES)
  ) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (mode),
    .strb         (strb),
    .enIn         (enIn),
    .busDominant  (busDominant),
    .filtDone     (filtDone),
    .rxdLow       (rxdLow),
    .txdStrong    (txdStrong),
    .inhOn        (inhOn),
    .termSel      (termEnc),
    .sleepPending (sleepPending)
  );

  assign modeOut = mode;
  assign termSel = termEnc;

endmodule

// File: rtl/linmc_checker.sv
module linmc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       porLow,
  input logic       enIn,
  input logic       wakeBus,
  input logic       wakeLocal,
  input logic [1:0] modeOut,
  input logic       rxdLow,
  input logic       txdStrong
);

  AST_POR_UNPOWERED: assert property (@(posedge clk) disable iff (!rstN)
    porLow |=> (modeOut == 2'd0)); // R1

  AST_NORM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 2'd2 && !enIn) |=> (modeOut != 2'd2)); // R3

  AST_WAKE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd3 && (wakeBus || wakeLocal) && !porLow) |=> (modeOut == 2'd1 && rxdLow)); // R6

  AST_WAKE_LOCAL_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd3 && wakeLocal && !porLow) |=> txdStrong); // R6

  AST_NORM_HOLDS_EN_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd2 && enIn && !porLow) |=> (modeOut == 2'd2)); // R7

  AST_STBY_PINS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && !enIn && !porLow) |=> ($stable(rxdLow) && $stable(txdStrong))); // R8

  AST_STBY_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'd1 && enIn && !porLow) |=> (modeOut != 2'd1 || (!rxdLow && !txdStrong))); // R9

endmodule

bind linmc_top linmc_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .porLow    (porLow),
  .enIn      (enIn),
  .wakeBus   (wakeBus),
  .wakeLocal (wakeLocal),
  .modeOut   (modeOut),
  .rxdLow    (rxdLow),
  .txdStrong (txdStrong)
);

// File: tb/linmc_top_bench.sv
`timescale 1ns/1ps
module linmc_top_bench;

  localparam int EN_N  = 4;
  localparam int DIS_N = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic porLow = 1'b1;
  logic enIn = 1'b0;
  logic wakeBus = 1'b0;
  logic wakeLocal = 1'b0;
  logic busDominant = 1'b0;
  logic [1:0] modeOut;
  logic rxdLow, txdStrong, inhOn, sleepPending;
  logic [1:0] termSel;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mMode = 0;
  int mRun = 0;
  bit mRxCfg = 1'b0;
  bit mTxCfg = 1'b0;

  always #4 clk = ~clk;

  linmc_top #(.EN_CYCLES(EN_N), .DIS_CYCLES(DIS_N)) u_linmc_top (
    .clk(clk), .rstN(rstN), .porLow(porLow), .enIn(enIn),
    .wakeBus(wakeBus), .wakeLocal(wakeLocal), .busDominant(busDominant),
    .modeOut(modeOut), .rxdLow(rxdLow), .txdStrong(txdStrong),
    .inhOn(inhOn), .termSel(termSel), .sleepPending(sleepPending)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expRxd();
    if (mMode == 1) return int'(mRxCfg);
    if (mMode == 2) return int'(busDominant);
    return 0;
  endfunction

  // reference model: advance on each edge, compare shortly after
  always @(posedge clk) begin
    int nMode;
    bit tgt;
    if (!rstN) begin
      mMode = 0; mRun = 0; mRxCfg = 0; mTxCfg = 0;
    end else begin
      nMode = mMode;
      if (porLow) nMode = 0;
      else if (mMode == 0) begin
        nMode = 1; mRxCfg = 0; mTxCfg = 0;
      end else if (mMode == 1) begin
        if (enIn) begin mRxCfg = 0; mTxCfg = 0; end
        if (enIn && mRun + 1 >= EN_N) nMode = 2;
      end else if (mMode == 2) begin
        if (!enIn && (wakeBus || wakeLocal)) begin
          nMode = 1; mRxCfg = 1; mTxCfg = wakeLocal;
        end else if (!enIn && mRun + 1 >= DIS_N) nMode = 3;
      end else begin
        if (wakeBus || wakeLocal) begin
          nMode = 1; mRxCfg = 1; mTxCfg = wakeLocal;
        end else if (enIn && mRun + 1 >= EN_N) nMode = 2;
      end
      tgt = (mMode != 2);
      if (nMode != mMode) mRun = 0;
      else if (enIn == tgt) mRun++;
      else mRun = 0;
      mMode = nMode;
    end
    #2;
    if (!finished) begin
      chk(int'(modeOut), mMode, "R3 mode");
      chk(int'(rxdLow), expRxd(), "R6 rxdLow");
      chk(int'(txdStrong), (mMode == 1) ? int'(mTxCfg) : 0, "R6 txdStrong");
      chk(int'(inhOn), (mMode == 1 || mMode == 2) ? 1 : 0, "R10 inhOn");
      chk(int'(termSel), (mMode == 0) ? 0 : (mMode == 3) ? 2 : 1, "R10 termSel");
      chk(int'(sleepPending), (mMode == 2 && !enIn) ? 1 : 0, "R12 sleepPending");
    end
  end

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseWake(input bit loc);
    if (loc) wakeLocal = 1'b1; else wakeBus = 1'b1;
    waitN(1);
    wakeLocal = 1'b0; wakeBus = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  initial begin
    waitN(2);
    chk(int'(modeOut), 0, "R1 reset mode");
    chk(int'(inhOn), 0, "R1 reset inh");
    chk(int'(termSel), 0, "R1 reset term");
    rstN = 1'b1;
    waitN(2);
    chk(int'(modeOut), 0, "R1 held unpowered");
    porLow = 1'b0;
    waitN(1);
    chk(int'(modeOut), 1, "R2 power-up standby");
    chk(int'(rxdLow), 0, "R2 rxd released");
    chk(int'(txdStrong), 0, "R2 txd weak");
    chk(int'(termSel), 1, "R10 standby term");
    pulseWake(1'b1);
    chk(int'(modeOut), 1, "R8 wake in standby mode");
    chk(int'(txdStrong), 0, "R8 wake in standby txd");
    // filter restart
    enIn = 1'b1; waitN(2);
    enIn = 1'b0; waitN(1);
    enIn = 1'b1; waitN(EN_N - 1);
    chk(int'(modeOut), 1, "R5 restart not done");
    waitN(1);
    chk(int'(modeOut), 2, "R3 standby to normal");
    busDominant = 1'b1; #1;
    chk(int'(rxdLow), 1, "R11 dominant");
    busDominant = 1'b0; #1;
    chk(int'(rxdLow), 0, "R11 recessive");
    waitN(1);
    pulseWake(1'b0);
    chk(int'(modeOut), 2, "R7 wake ignored enable high");
    enIn = 1'b0; #1;
    chk(int'(sleepPending), 1, "R12 window open");
    waitN(DIS_N - 1);
    chk(int'(modeOut), 2, "R4 not yet sleep");
    waitN(1);
    chk(int'(modeOut), 3, "R4 sleep");
    chk(int'(inhOn), 0, "R10 sleep inh");
    chk(int'(termSel), 2, "R10 sleep term");
    busDominant = 1'b1; #1;
    chk(int'(rxdLow), 0, "R11 ignored in sleep");
    busDominant = 1'b0;
    waitN(1);
    pulseWake(1'b0);
    chk(int'(modeOut), 1, "R6 bus wake mode");
    chk(int'(rxdLow), 1, "R6 bus wake rxd");
    chk(int'(txdStrong), 0, "R6 bus wake txd");
    pulseWake(1'b1);
    chk(int'(txdStrong), 0, "R8 second wake txd");
    chk(int'(rxdLow), 1, "R8 second wake rxd");
    enIn = 1'b1; waitN(1);
    chk(int'(rxdLow), 0, "R9 release rxd");
    chk(int'(modeOut), 1, "R9 still standby");
    enIn = 1'b0; waitN(1);
    chk(int'(rxdLow), 0, "R9 stays released");
    enIn = 1'b1; waitN(EN_N);
    chk(int'(modeOut), 2, "R3 normal again");
    enIn = 1'b0; waitN(2);
    pulseWake(1'b1);
    chk(int'(modeOut), 1, "R7 wake in window");
    chk(int'(rxdLow), 1, "R7 rxd low");
    chk(int'(txdStrong), 1, "R7 local strong");
    enIn = 1'b1; waitN(EN_N);
    enIn = 1'b0; waitN(DIS_N);
    chk(int'(modeOut), 3, "R4 sleep again");
    pulseWake(1'b1);
    chk(int'(txdStrong), 1, "R6 local wake strong");
    enIn = 1'b1; waitN(EN_N);
    enIn = 1'b0; waitN(DIS_N);
    enIn = 1'b1; waitN(EN_N - 1);
    chk(int'(modeOut), 3, "R3 sleep not yet");
    waitN(1);
    chk(int'(modeOut), 2, "R3 sleep to normal");
    porLow = 1'b1; waitN(1);
    chk(int'(modeOut), 0, "R1 drop from normal");
    chk(int'(rxdLow), 0, "R1 rxd float");
    porLow = 1'b0; waitN(1);
    chk(int'(modeOut), 1, "R2 repower standby");
    chk(int'(txdStrong), 0, "R2 repower txd");
    waitN(2);
    report();
  end

endmodule